// File: doc/BRIEF.md
# Snooping Coherent Data Cache Controller

This block controls a small direct-mapped data cache that belongs to one processor in a shared-bus multiprocessor. It answers the processor's loads and stores, fetches missing words from main memory over the shared bus, and keeps its copies consistent by watching the transactions other caches place on that bus. Each line holds one data word together with a valid bit, a dirty bit and a tag. The low address bits select the line.

Two mode inputs set the coherence behaviour. The first picks what happens when another cache's write hits a resident line: the line is either dropped or patched with the broadcast word. The second picks the store policy. In write-through mode every store goes to memory at once. In copy-back mode stores stay in the cache and mark the line dirty. A dirty line reaches memory when it is displaced, or when another processor reads that address on the bus. The modes are expected to change only while the controller is idle.

Top module: `snoop_cache`

## Requirements
- R1: After reset every line is invalid, `bus_req_o` and `cpu_ready_o` are low, and the first load to any address, including address 0, misses and goes to memory.
- R2: A load that hits asserts `cpu_ready_o` in the cycle it is presented, returns the stored word on `cpu_rdata_o`, and makes no bus transaction.
- R3: A load that misses keeps `cpu_ready_o` low. From the next cycle it raises a bus read (`bus_we_o`=0) at the requested address. After the acknowledge, the line holds the returned word and the load completes in the following cycle.
- R4: With `copy_back_i`=0, every store is sent as a bus write of its address and data. `cpu_ready_o` rises in the acknowledge cycle, and the line then holds the stored word and is clean.
- R5: With `update_mode_i`=0, a snooped write (`snp_we_i`=1) whose address hits a valid line clears that line, so the next load of that address misses.
- R6: With `update_mode_i`=1, a snooped write that hits a valid line replaces its word with `snp_data_i` and leaves it valid, so a later load hits with the new word.
- R7: A snooped write whose tag differs from the resident line leaves that line unchanged.
- R8: With `copy_back_i`=1, a store that hits, or whose line is invalid or clean, completes in the cycle it is presented with no bus transaction, and marks the line dirty.
- R9: With `copy_back_i`=1, a miss whose line is valid and dirty first writes the old word to memory at the old tag and index, then reads the new address.
- R10: With `copy_back_i`=1, a snooped read (`snp_we_i`=0) that hits a dirty line causes a bus write of that line. The line then stays valid and becomes clean, so a repeat snooped read causes no further write.
- R11: A snooped write and a processor load to the same line in the same cycle are resolved with the snoop first. An invalidate turns the load into a miss, and an update returns the broadcast word at once.
- R12: While `bus_req_o` is high and `bus_ack_i` is low, `cpu_ready_o` stays low, and `bus_we_o`, `bus_addr_o` and `bus_wdata_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| update_mode_i | input | 1 | 1: snooped write hits update the line; 0: they invalidate it |
| copy_back_i | input | 1 | 1: copy-back stores; 0: write-through stores |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 store, 0 load |
| cpu_addr_i | input | ADDR_W | Processor word address |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Load data, valid with ready |
| bus_req_o | output | 1 | Bus transaction pending |
| bus_we_o | output | 1 | 1 write or write-back, 0 read |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_ack_i | input | 1 | Memory completes the transaction this cycle |
| bus_rdata_i | input | DATA_W | Memory read data, valid with ack |
| snp_valid_i | input | 1 | Another cache's bus transaction is visible |
| snp_we_i | input | 1 | Snooped transaction is a write |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_data_i | input | DATA_W | Snooped write data |

## Verification
The bound checker watches these properties on every cycle: the effect of a snooped write on the line it hits, in either policy; that a write-through store goes straight onto the bus; that the bus request holds steady and the processor stalls while memory has not answered; and that every acknowledged write-back leaves its line clean. Other behaviour shows only over whole bench scenarios. These are the exact sequence of a dirty eviction followed by its fill, the single write-back a remote read triggers, the snoop-first outcome when both sides touch one line in one cycle, and the data returned through fills and updates, which the bench checks against its own memory model.

// File: rtl/snc_pkg.sv
package snc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_WTHRU,
    ST_FLUSH
  } ctl_state_e;
endpackage

// File: rtl/snc_array.sv
module snc_array #(
  parameter int LINES  = 16,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          snp_en_i,
  input  logic                          snp_inv_i,
  input  logic [$clog2(LINES)-1:0]      snp_idx_i,
  input  logic [DATA_W-1:0]             snp_data_i,
  input  logic                          clean_en_i,
  input  logic [$clog2(LINES)-1:0]      clean_idx_i,
  input  logic                          fill_en_i,
  input  logic [$clog2(LINES)-1:0]      fill_idx_i,
  input  logic [TAG_W-1:0]              fill_tag_i,
  input  logic [DATA_W-1:0]             fill_data_i,
  input  logic                          fill_dirty_i,
  output logic [LINES-1:0]              valid_o,
  output logic [LINES-1:0]              dirty_o,
  output logic [LINES-1:0][TAG_W-1:0]   tag_o,
  output logic [LINES-1:0][DATA_W-1:0]  data_o
);
  localparam int IDX_W = $clog2(LINES);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              v_q, d_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] w_q;

    // snoop first, then local writes override
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        t_q <= '0;
        w_q <= '0;
      end else begin
        if (snp_en_i && snp_idx_i == IDX_W'(i)) begin
          if (snp_inv_i) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
          end else begin
            w_q <= snp_data_i;
          end
        end
        if (clean_en_i && clean_idx_i == IDX_W'(i)) d_q <= 1'b0;
        if (fill_en_i && fill_idx_i == IDX_W'(i)) begin
          v_q <= 1'b1;
          d_q <= fill_dirty_i;
          t_q <= fill_tag_i;
          w_q <= fill_data_i;
        end
      end
    end

    assign valid_o[i] = v_q;
    assign dirty_o[i] = d_q;
    assign tag_o[i]   = t_q;
    assign data_o[i]  = w_q;
  end
endmodule

// File: rtl/snc_snoop.sv
module snc_snoop #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 16
) (
  input  logic                                         snp_valid_i,
  input  logic                                         snp_we_i,
  input  logic [ADDR_W-1:0]                            snp_addr_i,
  input  logic [DATA_W-1:0]                            snp_data_i,
  input  logic                                         update_mode_i,
  input  logic                                         copy_back_i,
  input  logic [LINES-1:0]                             valid_i,
  input  logic [LINES-1:0]                             dirty_i,
  input  logic [LINES-1:0][ADDR_W-$clog2(LINES)-1:0]   tag_i,
  output logic                                         wr_en_o,
  output logic                                         inv_o,
  output logic [$clog2(LINES)-1:0]                     idx_o,
  output logic [DATA_W-1:0]                            data_o,
  output logic [LINES-1:0]                             flush_set_o
);
  localparam int IDX_W = $clog2(LINES);

  logic hit;

  assign idx_o   = snp_addr_i[IDX_W-1:0];
  assign hit     = snp_valid_i && valid_i[idx_o] && tag_i[idx_o] == snp_addr_i[ADDR_W-1:IDX_W];
  assign wr_en_o = hit && snp_we_i;
  assign inv_o   = !update_mode_i;
  assign data_o  = snp_data_i;
  // remote read of a modified line schedules a write-back
  assign flush_set_o = (hit && !snp_we_i && copy_back_i && dirty_i[idx_o])
                       ? (LINES'(1) << idx_o) : '0;
endmodule

// File: rtl/snc_ctrl.sv
module snc_ctrl
  import snc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 16
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         copy_back_i,
  input  logic                                         cpu_req_i,
  input  logic                                         cpu_we_i,
  input  logic [ADDR_W-1:0]                            cpu_addr_i,
  input  logic [DATA_W-1:0]                            cpu_wdata_i,
  output logic                                         cpu_ready_o,
  output logic [DATA_W-1:0]                            cpu_rdata_o,
  input  logic [LINES-1:0]                             valid_i,
  input  logic [LINES-1:0]                             dirty_i,
  input  logic [LINES-1:0][ADDR_W-$clog2(LINES)-1:0]   tag_i,
  input  logic [LINES-1:0][DATA_W-1:0]                 data_i,
  input  logic                                         snp_wr_en_i,
  input  logic                                         snp_inv_i,
  input  logic [$clog2(LINES)-1:0]                     snp_idx_i,
  input  logic [DATA_W-1:0]                            snp_data_i,
  input  logic [LINES-1:0]                             flush_set_i,
  output logic                                         bus_req_o,
  output logic                                         bus_we_o,
  output logic [ADDR_W-1:0]                            bus_addr_o,
  output logic [DATA_W-1:0]                            bus_wdata_o,
  input  logic                                         bus_ack_i,
  input  logic [DATA_W-1:0]                            bus_rdata_i,
  output logic                                         clean_en_o,
  output logic [$clog2(LINES)-1:0]                     clean_idx_o,
  output logic                                         fill_en_o,
  output logic [$clog2(LINES)-1:0]                     fill_idx_o,
  output logic [ADDR_W-$clog2(LINES)-1:0]              fill_tag_o,
  output logic [DATA_W-1:0]                            fill_data_o,
  output logic                                         fill_dirty_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_state_e        state_q, state_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [LINES-1:0]  fl_q, fl_d, fl_live, fl_clr;
  logic [IDX_W-1:0]  fl_idx;

  logic [IDX_W-1:0]  c_idx;
  logic [TAG_W-1:0]  c_tag;
  logic              snp_here, e_valid, e_dirty, c_hit;
  logic [DATA_W-1:0] e_data;

  assign c_idx    = cpu_addr_i[IDX_W-1:0];
  assign c_tag    = cpu_addr_i[ADDR_W-1:IDX_W];
  // line as seen after this cycle's snoop
  assign snp_here = snp_wr_en_i && snp_idx_i == c_idx;
  assign e_valid  = valid_i[c_idx] && !(snp_here && snp_inv_i);
  assign e_dirty  = dirty_i[c_idx] && !(snp_here && snp_inv_i);
  assign e_data   = (snp_here && !snp_inv_i) ? snp_data_i : data_i[c_idx];
  assign c_hit    = e_valid && tag_i[c_idx] == c_tag;

  assign fl_live = fl_q & valid_i & dirty_i;
  assign fl_clr  = (state_q == ST_FLUSH && bus_ack_i) ? (LINES'(1) << addr_q[IDX_W-1:0]) : '0;
  assign fl_d    = (fl_live & ~fl_clr) | flush_set_i;

  always_comb begin
    fl_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (fl_live[i]) fl_idx = IDX_W'(i);
    end
  end

  always_comb begin
    state_d      = state_q;
    we_d         = we_q;
    addr_d       = addr_q;
    wdata_d      = wdata_q;
    cpu_ready_o  = 1'b0;
    clean_en_o   = 1'b0;
    clean_idx_o  = addr_q[IDX_W-1:0];
    fill_en_o    = 1'b0;
    fill_idx_o   = c_idx;
    fill_tag_o   = c_tag;
    fill_data_o  = cpu_wdata_i;
    fill_dirty_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (|fl_live) begin
          state_d = ST_FLUSH;
          we_d    = 1'b1;
          addr_d  = {tag_i[fl_idx], fl_idx};
          wdata_d = data_i[fl_idx];
        end else if (cpu_req_i) begin
          if (!cpu_we_i && c_hit) begin
            cpu_ready_o = 1'b1;
          end else if (cpu_we_i && !copy_back_i) begin
            state_d = ST_WTHRU;
            we_d    = 1'b1;
            addr_d  = cpu_addr_i;
            wdata_d = cpu_wdata_i;
          end else if (copy_back_i && !c_hit && e_valid && e_dirty) begin
            state_d = ST_EVICT;
            we_d    = 1'b1;
            addr_d  = {tag_i[c_idx], c_idx};
            wdata_d = e_data;
          end else if (cpu_we_i) begin
            fill_en_o    = 1'b1;
            fill_dirty_o = 1'b1;
            cpu_ready_o  = 1'b1;
          end else begin
            state_d = ST_FILL;
            we_d    = 1'b0;
            addr_d  = cpu_addr_i;
          end
        end
      end
      ST_EVICT, ST_FLUSH: begin
        if (bus_ack_i) begin
          clean_en_o = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      ST_FILL: begin
        if (bus_ack_i) begin
          fill_en_o   = 1'b1;
          fill_idx_o  = addr_q[IDX_W-1:0];
          fill_tag_o  = addr_q[ADDR_W-1:IDX_W];
          fill_data_o = bus_rdata_i;
          state_d     = ST_IDLE;
        end
      end
      ST_WTHRU: begin
        if (bus_ack_i) begin
          fill_en_o   = 1'b1;
          fill_idx_o  = addr_q[IDX_W-1:0];
          fill_tag_o  = addr_q[ADDR_W-1:IDX_W];
          fill_data_o = wdata_q;
          cpu_ready_o = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      fl_q    <= '0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      fl_q    <= fl_d;
    end
  end

  assign cpu_rdata_o = e_data;
  assign bus_req_o   = state_q != ST_IDLE;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
endmodule

// File: rtl/snoop_cache.sv
module snoop_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              update_mode_i,
  input  logic              copy_back_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic              snp_we_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [DATA_W-1:0] snp_data_i
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [LINES-1:0]              line_valid, line_dirty, flush_set;
  logic [LINES-1:0][TAG_W-1:0]   line_tag;
  logic [LINES-1:0][DATA_W-1:0]  line_data;
  logic                          snp_en, snp_inv, clean_en, fill_en, fill_dirty;
  logic [IDX_W-1:0]              snp_idx, clean_idx, fill_idx;
  logic [DATA_W-1:0]             snp_wdata, fill_data;
  logic [TAG_W-1:0]              fill_tag;

  snc_snoop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_snoop (
    .snp_valid_i   (snp_valid_i),
    .snp_we_i      (snp_we_i),
    .snp_addr_i    (snp_addr_i),
    .snp_data_i    (snp_data_i),
    .update_mode_i (update_mode_i),
    .copy_back_i   (copy_back_i),
    .valid_i       (line_valid),
    .dirty_i       (line_dirty),
    .tag_i         (line_tag),
    .wr_en_o       (snp_en),
    .inv_o         (snp_inv),
    .idx_o         (snp_idx),
    .data_o        (snp_wdata),
    .flush_set_o   (flush_set)
  );

  snc_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .snp_en_i     (snp_en),
    .snp_inv_i    (snp_inv),
    .snp_idx_i    (snp_idx),
    .snp_data_i   (snp_wdata),
    .clean_en_i   (clean_en),
    .clean_idx_i  (clean_idx),
    .fill_en_i    (fill_en),
    .fill_idx_i   (fill_idx),
    .fill_tag_i   (fill_tag),
    .fill_data_i  (fill_data),
    .fill_dirty_i (fill_dirty),
    .valid_o      (line_valid),
    .dirty_o      (line_dirty),
    .tag_o        (line_tag),
    .data_o       (line_data)
  );

  snc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .copy_back_i  (copy_back_i),
    .cpu_req_i    (cpu_req_i),
    .cpu_we_i     (cpu_we_i),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_ready_o  (cpu_ready_o),
    .cpu_rdata_o  (cpu_rdata_o),
    .valid_i      (line_valid),
    .dirty_i      (line_dirty),
    .tag_i        (line_tag),
    .data_i       (line_data),
    .snp_wr_en_i  (snp_en),
    .snp_inv_i    (snp_inv),
    .snp_idx_i    (snp_idx),
    .snp_data_i   (snp_wdata),
    .flush_set_i  (flush_set),
    .bus_req_o    (bus_req_o),
    .bus_we_o     (bus_we_o),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_ack_i    (bus_ack_i),
    .bus_rdata_i  (bus_rdata_i),
    .clean_en_o   (clean_en),
    .clean_idx_o  (clean_idx),
    .fill_en_o    (fill_en),
    .fill_idx_o   (fill_idx),
    .fill_tag_o   (fill_tag),
    .fill_data_o  (fill_data),
    .fill_dirty_o (fill_dirty)
  );
endmodule

// File: rtl/snc_checker.sv
module snc_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 16
) (
  input logic                                        clk_i,
  input logic                                        rst_ni,
  input logic                                        update_mode_i,
  input logic                                        copy_back_i,
  input logic                                        cpu_req_i,
  input logic                                        cpu_we_i,
  input logic [ADDR_W-1:0]                           cpu_addr_i,
  input logic                                        cpu_ready_o,
  input logic                                        bus_req_o,
  input logic                                        bus_we_o,
  input logic [ADDR_W-1:0]                           bus_addr_o,
  input logic [DATA_W-1:0]                           bus_wdata_o,
  input logic                                        bus_ack_i,
  input logic                                        snp_valid_i,
  input logic                                        snp_we_i,
  input logic [ADDR_W-1:0]                           snp_addr_i,
  input logic [DATA_W-1:0]                           snp_data_i,
  input logic [LINES-1:0]                            line_valid,
  input logic [LINES-1:0]                            line_dirty,
  input logic [LINES-1:0][ADDR_W-$clog2(LINES)-1:0]  line_tag,
  input logic [LINES-1:0][DATA_W-1:0]                line_data,
  input logic                                        fill_en,
  input logic [$clog2(LINES)-1:0]                    fill_idx
);
  localparam int IDX_W = $clog2(LINES);

  logic [IDX_W-1:0] s_idx;
  logic             s_wr_hit, s_free;

  assign s_idx    = snp_addr_i[IDX_W-1:0];
  assign s_wr_hit = snp_valid_i && snp_we_i && line_valid[s_idx]
                    && line_tag[s_idx] == snp_addr_i[ADDR_W-1:IDX_W];
  assign s_free   = !(fill_en && fill_idx == s_idx);

  assert_snoop_inv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_wr_hit && !update_mode_i && s_free) |=> !line_valid[$past(s_idx)]);

  assert_snoop_upd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_wr_hit && update_mode_i && s_free)
      |=> line_valid[$past(s_idx)] && line_data[$past(s_idx)] == $past(snp_data_i));

  assert_write_through_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i && !copy_back_i && !bus_req_o && line_dirty == '0)
      |=> bus_req_o && bus_we_o && bus_addr_o == $past(cpu_addr_i));

  assert_stall_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |-> !cpu_ready_o);

  assert_bus_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i)
      |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o));

  assert_writeback_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && bus_ack_i) |=> !line_dirty[$past(bus_addr_o[IDX_W-1:0])]);
endmodule

bind snoop_cache snc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .update_mode_i (update_mode_i),
  .copy_back_i   (copy_back_i),
  .cpu_req_i     (cpu_req_i),
  .cpu_we_i      (cpu_we_i),
  .cpu_addr_i    (cpu_addr_i),
  .cpu_ready_o   (cpu_ready_o),
  .bus_req_o     (bus_req_o),
  .bus_we_o      (bus_we_o),
  .bus_addr_o    (bus_addr_o),
  .bus_wdata_o   (bus_wdata_o),
  .bus_ack_i     (bus_ack_i),
  .snp_valid_i   (snp_valid_i),
  .snp_we_i      (snp_we_i),
  .snp_addr_i    (snp_addr_i),
  .snp_data_i    (snp_data_i),
  .line_valid    (line_valid),
  .line_dirty    (line_dirty),
  .line_tag      (line_tag),
  .line_data     (line_data),
  .fill_en       (fill_en),
  .fill_idx      (fill_idx)
);

// File: tb/snoop_cache_bench.sv
module snoop_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 16;
  localparam int NVEC       = 9;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wd;
    logic [DATA_W-1:0] exp;
    logic [3:0]        nbus;
  } vec_t;

  // memory initial content is 0x1000 + address
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h12, 16'h0000, 16'h1012, 4'd1},
    '{1'b0, 8'h12, 16'h0000, 16'h1012, 4'd0},
    '{1'b1, 8'h12, 16'hABCD, 16'h0000, 4'd1},
    '{1'b0, 8'h12, 16'h0000, 16'hABCD, 4'd0},
    '{1'b0, 8'h32, 16'h0000, 16'h1032, 4'd1},
    '{1'b0, 8'h12, 16'h0000, 16'hABCD, 4'd1},
    '{1'b1, 8'h45, 16'h5555, 16'h0000, 4'd1},
    '{1'b0, 8'h45, 16'h0000, 16'h5555, 4'd0},
    '{1'b0, 8'hFF, 16'h0000, 16'h10FF, 4'd1}
  };

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              upd = 1'b0, cb = 1'b0;
  logic              cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic              cpu_ready;
  logic [DATA_W-1:0] cpu_rdata;
  logic              bus_req, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic              bus_ack = 1'b0;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic              snp_valid = 1'b0, snp_we = 1'b0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic [DATA_W-1:0] snp_data = '0;

  int total = 0, bad = 0;
  logic [DATA_W-1:0] mem [256];
  logic              log_we   [64];
  logic [ADDR_W-1:0] log_addr [64];
  logic [DATA_W-1:0] log_data [64];
  int log_n = 0;
  int lat = 0;

  snoop_cache u_snoop_cache (
    .clk_i(clk), .rst_ni(rst_n), .update_mode_i(upd), .copy_back_i(cb),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .snp_valid_i(snp_valid), .snp_we_i(snp_we), .snp_addr_i(snp_addr), .snp_data_i(snp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i);

  // memory model: ack in the third cycle of each request
  always @(posedge clk) begin
    if (bus_ack) begin
      bus_ack <= 1'b0;
      if (bus_we) mem[bus_addr] <= bus_wdata;
      if (log_n < 64) begin
        log_we[log_n]   <= bus_we;
        log_addr[log_n] <= bus_addr;
        log_data[log_n] <= bus_wdata;
      end
      log_n <= log_n + 1;
    end else if (bus_req) begin
      if (lat == 1) begin
        bus_ack   <= 1'b1;
        bus_rdata <= mem[bus_addr];
        lat       <= 0;
      end else begin
        lat <= lat + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready(output logic [DATA_W-1:0] rd, output int waits);
    waits = 0;
    forever begin
      #(CLK_PERIOD/4);
      if (cpu_ready) break;
      waits++;
      if (waits > 200) begin
        check("watchdog access", 32'(waits), 32'd200);
        break;
      end
      @(negedge clk);
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic cpu_op(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                        output logic [DATA_W-1:0] rd, output int waits);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    wait_ready(rd, waits);
  endtask

  task automatic snoop_op(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    snp_valid = 1'b1; snp_we = we; snp_addr = a; snp_data = d;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  // snoop write and processor load presented in the same cycle
  task automatic both_op(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         output logic first_rdy, output logic [DATA_W-1:0] rd);
    int w;
    @(negedge clk);
    snp_valid = 1'b1; snp_we = 1'b1; snp_addr = a; snp_data = d;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    #(CLK_PERIOD/4);
    first_rdy = cpu_ready;
    rd = cpu_rdata;
    @(negedge clk);
    snp_valid = 1'b0;
    if (first_rdy) cpu_req = 1'b0;
    else wait_ready(rd, w);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] rd;
    int w, n0;
    logic fr;

    idle(3);
    rst_n = 1'b1;
    idle(1);
    #(CLK_PERIOD/4);
    check("R1 bus_req after reset", 32'(bus_req), 32'd0);
    check("R1 ready after reset", 32'(cpu_ready), 32'd0);
    n0 = log_n;
    cpu_op(1'b0, 8'h00, '0, rd, w);
    check("R1 address 0 misses", 32'(log_n - n0), 32'd1);
    check("R1 address 0 data", 32'(rd), 32'h1000);

    // R3 miss sequencing
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h77;
    #(CLK_PERIOD/4);
    check("R3 miss not ready", 32'(cpu_ready), 32'd0);
    @(negedge clk); #(CLK_PERIOD/4);
    check("R3 bus read raised", {bus_req, bus_we, 22'd0, bus_addr}, {1'b1, 1'b0, 22'd0, 8'h77});
    check("R12 stall while pending", 32'(cpu_ready), 32'd0);
    @(negedge clk); #(CLK_PERIOD/4);
    check("R12 request held", {bus_req, bus_we, 22'd0, bus_addr}, {1'b1, 1'b0, 22'd0, 8'h77});
    @(negedge clk);
    wait_ready(rd, w);
    check("R3 fill data", 32'(rd), 32'h1077);

    // table walk: write-through, invalidate policy
    for (int k = 0; k < NVEC; k++) begin
      n0 = log_n;
      cpu_op(VECS[k].we, VECS[k].addr, VECS[k].wd, rd, w);
      if (VECS[k].we) begin
        check("R4 store goes to bus", 32'(log_n - n0), 32'(VECS[k].nbus));
        check("R4 bus write data", 32'(mem[VECS[k].addr]), 32'(VECS[k].wd));
      end else if (VECS[k].nbus == 0) begin
        check("R2 hit data", 32'(rd), 32'(VECS[k].exp));
        check("R2 hit no bus", 32'(log_n - n0), 32'd0);
      end else begin
        check("R3 miss data", 32'(rd), 32'(VECS[k].exp));
        check("R3 miss one read", 32'(log_n - n0), 32'd1);
      end
    end

    // R7 tag mismatch ignored
    cpu_op(1'b0, 8'h20, '0, rd, w);
    snoop_op(1'b1, 8'h30, 16'hDEAD);
    n0 = log_n;
    cpu_op(1'b0, 8'h20, '0, rd, w);
    check("R7 other tag ignored data", 32'(rd), 32'h1020);
    check("R7 other tag still hits", 32'(log_n - n0), 32'd0);

    // R5 invalidate
    snoop_op(1'b1, 8'h20, 16'h9999);
    n0 = log_n;
    cpu_op(1'b0, 8'h20, '0, rd, w);
    check("R5 invalidated line misses", 32'(log_n - n0), 32'd1);
    check("R5 refetched data", 32'(rd), 32'h1020);

    // R6 update
    upd = 1'b1;
    snoop_op(1'b1, 8'h20, 16'h7777);
    n0 = log_n;
    cpu_op(1'b0, 8'h20, '0, rd, w);
    check("R6 updated data", 32'(rd), 32'h7777);
    check("R6 updated line hits", 32'(log_n - n0), 32'd0);

    // R11 same-cycle snoop and load
    both_op(8'h20, 16'h6666, fr, rd);
    check("R11 update first ready", 32'(fr), 32'd1);
    check("R11 update first data", 32'(rd), 32'h6666);
    upd = 1'b0;
    n0 = log_n;
    both_op(8'h20, 16'h5555, fr, rd);
    check("R11 invalidate first stalls", 32'(fr), 32'd0);
    check("R11 invalidate then refetch", 32'(log_n - n0), 32'd1);
    check("R11 refetched data", 32'(rd), 32'h1020);

    // copy-back
    cb = 1'b1;
    n0 = log_n;
    cpu_op(1'b1, 8'h50, 16'h1111, rd, w);
    check("R8 store no wait", 32'(w), 32'd0);
    check("R8 store no bus", 32'(log_n - n0), 32'd0);
    cpu_op(1'b0, 8'h50, '0, rd, w);
    check("R8 dirty data readable", 32'(rd), 32'h1111);
    check("R8 memory not yet written", 32'(mem[8'h50]), 32'h1050);

    // R10 remote read flush
    n0 = log_n;
    snoop_op(1'b0, 8'h50, '0);
    idle(8);
    check("R10 one write-back", 32'(log_n - n0), 32'd1);
    check("R10 write-back txn", {log_we[n0], 23'd0, log_addr[n0]}, {1'b1, 23'd0, 8'h50});
    check("R10 memory updated", 32'(mem[8'h50]), 32'h1111);
    n0 = log_n;
    snoop_op(1'b0, 8'h50, '0);
    idle(8);
    check("R10 clean after flush", 32'(log_n - n0), 32'd0);
    cpu_op(1'b0, 8'h50, '0, rd, w);
    check("R10 line stays valid", 32'(log_n - n0), 32'd0);
    check("R10 data kept", 32'(rd), 32'h1111);

    // R9 dirty eviction before fill
    cpu_op(1'b1, 8'h50, 16'h2222, rd, w);
    n0 = log_n;
    cpu_op(1'b0, 8'h60, '0, rd, w);
    check("R9 two transactions", 32'(log_n - n0), 32'd2);
    check("R9 write-back first", {log_we[n0], 7'd0, log_addr[n0], log_data[n0]},
          {1'b1, 7'd0, 8'h50, 16'h2222});
    check("R9 fill second", {log_we[n0+1], 23'd0, log_addr[n0+1]}, {1'b0, 23'd0, 8'h60});
    check("R9 fill data", 32'(rd), 32'h1060);

    // R8 store over clean victim
    n0 = log_n;
    cpu_op(1'b1, 8'h70, 16'h3333, rd, w);
    check("R8 clean victim store no wait", 32'(w), 32'd0);
    check("R8 clean victim store no bus", 32'(log_n - n0), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule